// File: doc/BRIEF.md
# Two-Channel Byte DMA for a Serial Peripheral

This block moves bytes between system memory and a byte-wide serial peripheral. The transmit channel reads memory one byte at a time and hands each byte to the peripheral. The receive channel accepts bytes from the peripheral and writes each one to memory. Software programs a start address, a byte count and an upper-address bit for each channel. It then picks the direction and writes the start command. When the last byte has moved, the block raises a completion flag and, if enabled, an interrupt.

Each channel address is 33 bits wide: a 32-bit address register plus a one-bit register that supplies bit 32. A chained mode runs the full transmit transfer and then the full receive transfer from one start command. This serves a write-then-read transaction on the serial bus. A hold-reset register aborts any transfer and keeps the engine idle until software releases it.

The memory side is a single-beat request/acknowledge port. On a read, the data arrives in the acknowledge cycle. The peripheral side uses one valid/ready byte handshake in each direction.

Top module: `pdma_top`

## Requirements
- R1: After reset every register reads 0. `mem_req`, `tx_valid`, `rx_ready` and `irq` are all low.
- R2: With control bit0 = 0 and bit1 = 0, a start command reads `len` bytes from ascending consecutive addresses starting at the transmit base. Each byte is presented on `tx_data` in the same order. This holds for every length up to the largest count the length field holds. While `tx_valid` waits for `tx_ready`, the byte stays stable.
- R3: With control bit0 = 1, a start command takes `len` bytes from the receive port. It writes them in arrival order to ascending consecutive addresses starting at the receive base. While `mem_req` waits for `mem_ack`, the address stays stable.
- R4: Bit0 of a channel's upper-address register (transmit at 0x54, receive at 0x58) becomes bit 32 of that channel's address. The address steps as one 33-bit counter, so a carry out of bit 31 reaches bit 32.
- R5: With control bit1 = 1 and bit0 = 0, the transmit transfer finishes completely before the receive channel requests any byte or memory write. The receive transfer then runs with its own base and count.
- R6: Bit0 of the flag register (0x00) rises only as a transfer finishes, and the engine is idle when it rises. `irq` equals that flag ANDed with bit0 of the interrupt-enable register (0x04). Writing the flag register with bit0 = 0 clears it. Writing it with bit0 = 1 leaves it unchanged.
- R7: A start command with a count of 0 sets the flag. It causes no memory and no peripheral handshake.
- R8: Writing a value with bit1 = 1 to the reset register (0x0C) holds the engine in reset from the next cycle on. Any transfer is dropped, the request and handshake outputs go low, and the flag clears. Start commands are ignored while held. Writing 0 releases the hold, and later transfers run normally.
- R9: A start command written while a transfer is in progress has no effect, so no extra bytes move.
- R10: The enable register (0x08) reads 1 from the cycle after an accepted start command until the transfer is finished. Otherwise it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write (receive channel), 0 = read (transmit channel) |
| mem_addr | output | 33 | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| tx_valid | output | 1 | Byte offered to the peripheral |
| tx_data | output | 8 | Byte to the peripheral |
| tx_ready | input | 1 | Peripheral accepts the byte |
| rx_valid | input | 1 | Peripheral offers a byte |
| rx_data | input | 8 | Byte from the peripheral |
| rx_ready | output | 1 | Block accepts the byte |

## Verification
The bench builds the block with a 6-bit length field. This makes 63, the largest count, cheap enough to run as one full transfer, so the end of the count range is exercised and not only small counts. The address counter is 33 bits regardless of the parameter. A transmit base two below the 4 GiB boundary therefore drives the carry into bit 32 within a few bytes. The memory acknowledge latency, the peripheral ready pattern and the receive valid pattern vary from cycle to cycle, so the hold-while-waiting rules are exercised under stalls.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int PA_LO_W = 32;
    localparam int PA_W    = PA_LO_W + 1;

    typedef logic [PA_W-1:0] paddr_t;

    // register byte offsets
    localparam logic [7:0] OFF_FLAG = 8'h00;
    localparam logic [7:0] OFF_IEN  = 8'h04;
    localparam logic [7:0] OFF_GO   = 8'h08;
    localparam logic [7:0] OFF_RST  = 8'h0C;
    localparam logic [7:0] OFF_CTL  = 8'h18;
    localparam logic [7:0] OFF_TXA  = 8'h1C;
    localparam logic [7:0] OFF_RXA  = 8'h20;
    localparam logic [7:0] OFF_TXL  = 8'h24;
    localparam logic [7:0] OFF_RXL  = 8'h28;
    localparam logic [7:0] OFF_TXH  = 8'h54;
    localparam logic [7:0] OFF_RXH  = 8'h58;

    localparam int HOLD_BIT = 1;

    typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RX} phase_e;
    typedef enum logic [1:0] {CH_IDLE, CH_MEM, CH_PER, CH_FIN} chan_e;

    // bit1 = chain receive after transmit, bit0 = peripheral-to-memory
    typedef struct packed {
        logic chain;
        logic to_mem;
    } ctl_t;

    function automatic paddr_t addr_step(paddr_t a);
        return a + PA_W'(1);
    endfunction

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs import pdma_pkg::*; #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [7:0]       waddr,
    input  logic [31:0]      wdata,
    input  logic [7:0]       raddr,
    output logic [31:0]      rdata,
    input  logic             busy,
    input  logic             done_set,
    output logic             go,
    output logic             hold_next,
    output logic             hold,
    output logic             flag,
    output logic             irq,
    output ctl_t             ctl,
    output paddr_t           tx_base,
    output paddr_t           rx_base,
    output logic [LEN_W-1:0] tx_len,
    output logic [LEN_W-1:0] rx_len
);

    logic             ien_q, txh_q, rxh_q, hold_q, flag_q;
    ctl_t             ctl_q;
    logic [31:0]      txa_q, rxa_q;
    logic [LEN_W-1:0] txl_q, rxl_q;

    always_comb begin
        hold_next = (we && waddr == OFF_RST) ? wdata[HOLD_BIT] : hold_q;
        go        = we && (waddr == OFF_GO) && wdata[0] && !hold_next && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= 1'b0;
            txh_q  <= 1'b0;
            rxh_q  <= 1'b0;
            hold_q <= 1'b0;
            flag_q <= 1'b0;
            ctl_q  <= '0;
            txa_q  <= '0;
            rxa_q  <= '0;
            txl_q  <= '0;
            rxl_q  <= '0;
        end else begin
            if (we) begin
                case (waddr)
                    OFF_IEN: ien_q <= wdata[0];
                    OFF_CTL: ctl_q <= ctl_t'(wdata[1:0]);
                    OFF_TXA: txa_q <= wdata;
                    OFF_RXA: rxa_q <= wdata;
                    OFF_TXL: txl_q <= wdata[LEN_W-1:0];
                    OFF_RXL: rxl_q <= wdata[LEN_W-1:0];
                    OFF_TXH: txh_q <= wdata[0];
                    OFF_RXH: rxh_q <= wdata[0];
                    default: ;
                endcase
            end
            hold_q <= hold_next;
            if (hold_next)
                flag_q <= 1'b0;
            else if (done_set)
                flag_q <= 1'b1;
            else if (we && waddr == OFF_FLAG && !wdata[0])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (raddr)
            OFF_FLAG: rdata = 32'(flag_q);
            OFF_IEN:  rdata = 32'(ien_q);
            OFF_GO:   rdata = 32'(busy);
            OFF_RST:  rdata = {30'd0, hold_q, 1'b0};
            OFF_CTL:  rdata = 32'(ctl_q);
            OFF_TXA:  rdata = txa_q;
            OFF_RXA:  rdata = rxa_q;
            OFF_TXL:  rdata = 32'(txl_q);
            OFF_RXL:  rdata = 32'(rxl_q);
            OFF_TXH:  rdata = 32'(txh_q);
            OFF_RXH:  rdata = 32'(rxh_q);
            default:  rdata = '0;
        endcase
    end

    assign hold    = hold_q;
    assign flag    = flag_q;
    assign irq     = flag_q & ien_q;
    assign ctl     = ctl_q;
    assign tx_base = {txh_q, txa_q};
    assign rx_base = {rxh_q, rxa_q};
    assign tx_len  = txl_q;
    assign rx_len  = rxl_q;

endmodule

// File: rtl/pdma_seq.sv
module pdma_seq import pdma_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic go,
    input  ctl_t ctl,
    input  logic tx_done,
    input  logic rx_done,
    output logic tx_start,
    output logic rx_start,
    output logic busy,
    output logic done_set
);

    phase_e phase_q;
    logic   chain_q;

    always_comb begin
        tx_start = go && !ctl.to_mem;
        rx_start = (go && ctl.to_mem) || (phase_q == PH_TX && tx_done && chain_q);
        done_set = (phase_q == PH_TX && tx_done && !chain_q) ||
                   (phase_q == PH_RX && rx_done);
        busy     = (phase_q != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= PH_IDLE;
            chain_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: if (go) begin
                    phase_q <= ctl.to_mem ? PH_RX : PH_TX;
                    chain_q <= ctl.chain && !ctl.to_mem;
                end
                PH_TX: if (tx_done) phase_q <= chain_q ? PH_RX : PH_IDLE;
                PH_RX: if (rx_done) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pdma_txch.sv
module pdma_txch import pdma_pkg::*; #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  paddr_t           base,
    input  logic [LEN_W-1:0] len,
    output logic             mem_req,
    output paddr_t           mem_addr,
    input  logic             mem_ack,
    input  logic [7:0]       mem_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    output logic             done,
    output logic             busy
);

    chan_e            st_q;
    paddr_t           cur_q;
    logic [LEN_W-1:0] left_q;
    logic [7:0]       byte_q;
    logic             last;

    assign last = (left_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q   <= CH_IDLE;
            cur_q  <= '0;
            left_q <= '0;
            byte_q <= '0;
        end else begin
            case (st_q)
                CH_IDLE: if (start) begin
                    cur_q  <= base;
                    left_q <= len;
                    st_q   <= (len == '0) ? CH_FIN : CH_MEM;
                end
                CH_MEM: if (mem_ack) begin
                    byte_q <= mem_rdata;
                    st_q   <= CH_PER;
                end
                CH_PER: if (tx_ready) begin
                    cur_q  <= addr_step(cur_q);
                    left_q <= left_q - LEN_W'(1);
                    st_q   <= last ? CH_FIN : CH_MEM;
                end
                CH_FIN:  st_q <= CH_IDLE;
                default: st_q <= CH_IDLE;
            endcase
        end
    end

    assign mem_req  = (st_q == CH_MEM);
    assign mem_addr = cur_q;
    assign tx_valid = (st_q == CH_PER);
    assign tx_data  = byte_q;
    assign done     = (st_q == CH_FIN);
    assign busy     = (st_q != CH_IDLE);

endmodule

// File: rtl/pdma_rxch.sv
module pdma_rxch import pdma_pkg::*; #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  paddr_t           base,
    input  logic [LEN_W-1:0] len,
    output logic             mem_req,
    output paddr_t           mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic             mem_ack,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             done
);

    chan_e            st_q;
    paddr_t           cur_q;
    logic [LEN_W-1:0] left_q;
    logic [7:0]       byte_q;
    logic             last;

    assign last = (left_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q   <= CH_IDLE;
            cur_q  <= '0;
            left_q <= '0;
            byte_q <= '0;
        end else begin
            case (st_q)
                CH_IDLE: if (start) begin
                    cur_q  <= base;
                    left_q <= len;
                    st_q   <= (len == '0) ? CH_FIN : CH_PER;
                end
                CH_PER: if (rx_valid) begin
                    byte_q <= rx_data;
                    st_q   <= CH_MEM;
                end
                CH_MEM: if (mem_ack) begin
                    cur_q  <= addr_step(cur_q);
                    left_q <= left_q - LEN_W'(1);
                    st_q   <= last ? CH_FIN : CH_PER;
                end
                CH_FIN:  st_q <= CH_IDLE;
                default: st_q <= CH_IDLE;
            endcase
        end
    end

    assign mem_req   = (st_q == CH_MEM);
    assign mem_addr  = cur_q;
    assign mem_wdata = byte_q;
    assign rx_ready  = (st_q == CH_PER);
    assign done      = (st_q == CH_FIN);

endmodule

// File: rtl/pdma_top.sv
module pdma_top import pdma_pkg::*; #(
    parameter int LEN_W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [7:0]    reg_waddr,
    input  logic [31:0]   reg_wdata,
    input  logic [7:0]    reg_raddr,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [PA_W-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          rx_ready
);

    logic             busy, done_set, go, hold_next, hold_q, flag;
    ctl_t             ctl;
    paddr_t           tx_base, rx_base, tx_addr, rx_addr;
    logic [LEN_W-1:0] tx_len, rx_len;
    logic             tx_start, rx_start, tx_done, rx_done, tx_busy;
    logic             tx_req, rx_req;

    pdma_regs #(.LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .rdata(reg_rdata), .busy(busy), .done_set(done_set),
        .go(go), .hold_next(hold_next), .hold(hold_q), .flag(flag), .irq(irq),
        .ctl(ctl), .tx_base(tx_base), .rx_base(rx_base),
        .tx_len(tx_len), .rx_len(rx_len)
    );

    pdma_seq u_seq (
        .clk(clk), .rst(rst), .clr(hold_next), .go(go), .ctl(ctl),
        .tx_done(tx_done), .rx_done(rx_done), .tx_start(tx_start),
        .rx_start(rx_start), .busy(busy), .done_set(done_set)
    );

    pdma_txch #(.LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst(rst), .clr(hold_next), .start(tx_start),
        .base(tx_base), .len(tx_len), .mem_req(tx_req), .mem_addr(tx_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .done(tx_done), .busy(tx_busy)
    );

    pdma_rxch #(.LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst(rst), .clr(hold_next), .start(rx_start),
        .base(rx_base), .len(rx_len), .mem_req(rx_req), .mem_addr(rx_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .done(rx_done)
    );

    // only one channel is ever active, so a plain select suffices
    assign mem_req  = tx_req | rx_req;
    assign mem_we   = rx_req;
    assign mem_addr = rx_req ? rx_addr : tx_addr;

endmodule

// File: rtl/pdma_chk.sv
module pdma_chk (
    input logic        clk,
    input logic        rst,
    input logic        hold,
    input logic        busy,
    input logic        flag,
    input logic        tx_busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [32:0] mem_addr,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        rx_ready
);

    // R8
    quiet_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold |-> (!mem_req && !tx_valid && !rx_ready && !busy));

    // R8
    flag_low_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold |-> !flag);

    // R2
    tx_byte_hold_chk: assert property (@(posedge clk) disable iff (rst || hold)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R3
    mem_addr_hold_chk: assert property (@(posedge clk) disable iff (rst || hold)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5
    tx_before_rx_chk: assert property (@(posedge clk) disable iff (rst)
        tx_busy |-> (!rx_ready && !(mem_req && mem_we)));

    // R6
    flag_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(busy) && !busy));

endmodule

bind pdma_top pdma_chk u_chk (
    .clk(clk), .rst(rst), .hold(hold_q), .busy(busy), .flag(flag),
    .tx_busy(tx_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_ready(rx_ready)
);

// File: tb/sim_pdma_top.sv
`timescale 1ns/1ps
module sim_pdma_top;

    localparam int LW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, mem_we;
    logic [32:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;

    always #2 clk = ~clk;

    pdma_top #(.LEN_W(LW)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [32:0] a);
        return a[7:0] ^ a[15:8] ^ {7'd0, a[32]} ^ 8'h5A;
    endfunction

    // behavioural reference model state
    logic [32:0] tx_rd_next, tx_send_next, rx_wr_next;
    int          tx_rd_left = 0, tx_left = 0, wr_count = 0, act_count = 0;
    logic [7:0]  rxq[$];
    logic [7:0]  exp_wd[$];
    int          cyc = 0, mwait = 0, mlat = 0;

    always @(negedge clk) begin
        cyc++;
        if (mem_req) begin
            if (mwait >= mlat) begin
                mem_ack = 1'b1; mwait = 0; mlat = (mlat + 1) % 3;
            end else begin
                mem_ack = 1'b0; mwait++;
            end
        end else begin
            mem_ack = 1'b0; mwait = 0;
        end
        mem_rdata = mbyte(mem_addr);
        if (!rst && mem_req && mem_ack) begin
            act_count++;
            if (mem_we) begin
                chk(exp_wd.size() > 0, "R3 unexpected memory write", 64'(mem_addr), 0);
                if (exp_wd.size() > 0) begin
                    chk(mem_addr == rx_wr_next, "R3/R4 write address", 64'(mem_addr), 64'(rx_wr_next));
                    chk(mem_wdata == exp_wd[0], "R3 write data", 64'(mem_wdata), 64'(exp_wd[0]));
                    void'(exp_wd.pop_front());
                    rx_wr_next = rx_wr_next + 33'd1;
                    wr_count++;
                end
            end else begin
                chk(tx_rd_left > 0, "R2/R9 unexpected memory read", 64'(mem_addr), 0);
                if (tx_rd_left > 0) begin
                    chk(mem_addr == tx_rd_next, "R2/R4 read address", 64'(mem_addr), 64'(tx_rd_next));
                    tx_rd_next = tx_rd_next + 33'd1;
                    tx_rd_left--;
                end
            end
        end
        tx_ready = (cyc % 4) != 2;
        if (!rst && tx_valid && tx_ready) begin
            act_count++;
            chk(tx_left > 0, "R2/R9 unexpected peripheral byte", 64'(tx_data), 0);
            if (tx_left > 0) begin
                chk(tx_data == mbyte(tx_send_next), "R2 byte order", 64'(tx_data), 64'(mbyte(tx_send_next)));
                tx_send_next = tx_send_next + 33'd1;
                tx_left--;
            end
        end
        rx_valid = (rxq.size() > 0) && ((cyc % 3) != 1);
        rx_data  = (rxq.size() > 0) ? rxq[0] : 8'h00;
        if (!rst && rx_valid && rx_ready) begin
            act_count++;
            chk(tx_left == 0, "R5 receive before transmit done", 64'(tx_left), 0);
            exp_wd.push_back(rxq.pop_front());
        end
    end

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_raddr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(irq, tag, 64'(irq), 1);
    endtask

    task automatic run_tx(input logic [31:0] a, input logic hi, input int n);
        tx_rd_next = {hi, a}; tx_send_next = {hi, a};
        tx_rd_left = n; tx_left = n;
        wreg(8'h1C, a); wreg(8'h54, 32'(hi)); wreg(8'h24, 32'(n)); wreg(8'h18, 0);
        wreg(8'h08, 1);
    endtask

    task automatic finish_tb();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_tb();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rreg(8'h00, d); chk(d == 0, "R1 flag after reset", 64'(d), 0);
        rreg(8'h08, d); chk(d == 0, "R1 enable after reset", 64'(d), 0);
        rreg(8'h1C, d); chk(d == 0, "R1 tx address after reset", 64'(d), 0);
        rreg(8'h58, d); chk(d == 0, "R1 rx upper after reset", 64'(d), 0);
        chk(!mem_req && !tx_valid && !rx_ready && !irq, "R1 outputs idle", 64'({mem_req, tx_valid, rx_ready, irq}), 0);

        wreg(8'h04, 1);

        // R2, R9, R10 transmit
        run_tx(32'h100, 1'b0, 5);
        rreg(8'h08, d); chk(d == 1, "R10 busy during transfer", 64'(d), 1);
        wreg(8'h08, 1);  // R9 start while busy
        wait_irq("R2 transmit completes");
        chk(tx_left == 0 && tx_rd_left == 0, "R2/R9 byte count", 64'(tx_left + tx_rd_left), 0);
        rreg(8'h08, d); chk(d == 0, "R10 idle after transfer", 64'(d), 0);
        rreg(8'h00, d); chk(d == 1, "R6 flag set", 64'(d), 1);
        wreg(8'h00, 1);
        rreg(8'h00, d); chk(d == 1, "R6 writing 1 keeps flag", 64'(d), 1);
        wreg(8'h00, 0);
        rreg(8'h00, d); chk(d == 0 && !irq, "R6 writing 0 clears flag and irq", 64'({d[0], irq}), 0);

        // R3, R4 receive with upper bit set
        rx_wr_next = 33'h1_0000_0200; wr_count = 0;
        rxq.push_back(8'h11); rxq.push_back(8'hA2); rxq.push_back(8'h3C); rxq.push_back(8'hF4);
        wreg(8'h20, 32'h200); wreg(8'h58, 1); wreg(8'h28, 4); wreg(8'h18, 1);
        wreg(8'h08, 1);
        wait_irq("R3 receive completes");
        chk(wr_count == 4 && exp_wd.size() == 0, "R3 all bytes written", 64'(wr_count), 4);
        chk(rx_wr_next == 33'h1_0000_0204, "R4 receive upper bit used", 64'(rx_wr_next), 64'(33'h1_0000_0204));
        wreg(8'h00, 0);

        // R4 carry into bit 32
        run_tx(32'hFFFF_FFFE, 1'b0, 4);
        wait_irq("R4 carry transfer completes");
        chk(tx_rd_next == 33'h1_0000_0002 && tx_left == 0, "R4 carry reached bit 32", 64'(tx_rd_next), 64'(33'h1_0000_0002));
        wreg(8'h00, 0);

        // R2 largest count with upper bit on the transmit side
        run_tx(32'h300, 1'b1, 63);
        wait_irq("R2 full-count transfer completes");
        chk(tx_left == 0 && tx_rd_left == 0, "R2 all 63 bytes moved", 64'(tx_left), 0);
        wreg(8'h00, 0);

        // R5 chained write-then-read
        tx_rd_next = 33'h40; tx_send_next = 33'h40; tx_rd_left = 3; tx_left = 3;
        rx_wr_next = 33'h80; wr_count = 0;
        rxq.push_back(8'h77); rxq.push_back(8'h08);
        wreg(8'h1C, 32'h40); wreg(8'h54, 0); wreg(8'h24, 3);
        wreg(8'h20, 32'h80); wreg(8'h58, 0); wreg(8'h28, 2);
        wreg(8'h18, 2);
        wreg(8'h08, 1);
        wait_irq("R5 chained transfer completes");
        chk(tx_left == 0 && wr_count == 2, "R5 both phases moved", 64'(wr_count), 2);
        wreg(8'h00, 0);

        // R7 zero count
        begin
            int snap;
            snap = act_count;
            wreg(8'h24, 0); wreg(8'h18, 0);
            wreg(8'h08, 1);
            rreg(8'h08, d); chk(d == 1, "R10 busy for zero count", 64'(d), 1);
            rreg(8'h00, d); chk(d == 1, "R7 zero count sets flag", 64'(d), 1);
            chk(act_count == snap, "R7 no handshakes", 64'(act_count - snap), 0);
        end

        // R8 hold-reset mid transfer (flag left set on purpose)
        run_tx(32'h500, 1'b0, 10);
        repeat (8) @(negedge clk);
        wreg(8'h0C, 2);
        @(negedge clk);
        chk(!mem_req && !tx_valid, "R8 outputs dropped in hold", 64'({mem_req, tx_valid}), 0);
        rreg(8'h00, d); chk(d == 0, "R8 hold clears flag", 64'(d), 0);
        rreg(8'h0C, d); chk(d == 2, "R8 hold readback", 64'(d), 2);
        tx_rd_left = 0; tx_left = 0;
        wreg(8'h08, 1);
        rreg(8'h08, d); chk(d == 0, "R8 start ignored in hold", 64'(d), 0);
        wreg(8'h0C, 0);
        run_tx(32'h600, 1'b0, 2);
        wait_irq("R8 transfer after release");
        chk(tx_left == 0, "R8 release restores operation", 64'(tx_left), 0);

        finish_tb();
    end

endmodule